// File: doc/BRIEF.md
# Channel to PLL Divider Setting Calculator

This block turns a radio channel centre frequency into the three divider settings of a pulse-swallow synthesiser: the main programmable count, the swallow count and the reference count. The channel is given as an integer number of kHz, along with a code that selects a comparison step of 25, 12.5 or 6.25 kHz and a bit that selects a dual-modulus prescaler of 64 or 128. Inside, all frequencies are kept in quarter-kHz units, so every step is an exact integer.

A job starts with a one-cycle `start_i` pulse while the block is idle. The controller passes through five named states. IDLE latches the request on `start_i` (IDLE to OFFSET). OFFSET removes the fixed 21700 kHz intermediate offset to form the oscillator target and launches the divider (OFFSET to DIVIDE). DIVIDE waits for a restoring shift-subtract divider, which produces one quotient bit per clock (DIVIDE to SPLIT on divider completion). SPLIT takes the quotient apart into the main and swallow counts with a shift and a mask, checks legality, and registers the results (SPLIT to FINISH). FINISH raises `done_o` for one cycle (FINISH to IDLE). The reference count comes from the fixed 21.25 MHz reference divided by the chosen step.

Top module: `pll_chan_calc`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are 0.
- R2: The total division equals (channel kHz − 21700) divided by the step, where `step_sel_i` 00 selects 25 kHz, 01 selects 12.5 kHz and 10 selects 6.25 kHz.
- R3: `r_cnt_o` is 850 for step code 00, 1700 for 01 and 3400 for 10.
- R4: With `m128_i`=0 the modulus is 64 and `n_cnt_o` = total/64, `a_cnt_o` = total mod 64; with `m128_i`=1 the modulus is 128 and the same split uses 128.
- R5: `done_o` is high for exactly one cycle, `busy_o` is high while it is, and both are low on the following cycle.
- R6: `done_o` rises no more than 27 clock edges after the edge that accepts `start_i` (default 21-bit channel width).
- R7: `err_o` is 1 when the target frequency is not an exact multiple of the step.
- R8: `err_o` is 1 when the main count is outside 3 to 2047 or the swallow count is not below the main count; both limits are legal.
- R9: `err_o` is 1 when the channel is at or below 21700 kHz, or when `step_sel_i` is 11.
- R10: A `start_i` pulse while `busy_o` is high is ignored: the running job's results are kept and no second `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| chan_khz_i | input | 21 | Channel centre frequency in kHz |
| step_sel_i | input | 2 | Comparison step code (00 25 kHz, 01 12.5 kHz, 10 6.25 kHz, 11 illegal) |
| m128_i | input | 1 | Prescaler modulus select (0 = 64, 1 = 128) |
| busy_o | output | 1 | High from the cycle after acceptance to the done cycle |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Result is illegal, valid with `done_o` |
| n_cnt_o | output | 11 | Main programmable count |
| a_cnt_o | output | 7 | Swallow count |
| r_cnt_o | output | 14 | Reference count |

## Verification
Every cycle, the assertions check the single-cycle done pulse inside the busy window, the latency bound, the divider's partial remainder staying below the divisor, the request registers holding while busy, and that any result reported as legal meets the count limits and reference ratio. Only the bench's scenarios show that the computed counts are the right numbers for a given channel, step and modulus, that each error cause really raises the flag, and that an extra request during a job leaves the outputs unchanged.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

    localparam int unsigned QTR_PER_KHZ = 4;
    localparam int unsigned OFFSET_KHZ  = 21700;
    localparam int unsigned REF_KHZ     = 21250;
    localparam int unsigned OFFSET_Q    = OFFSET_KHZ * QTR_PER_KHZ;
    localparam int unsigned REF_Q       = REF_KHZ * QTR_PER_KHZ;
    localparam int unsigned STEP_W      = 7;
    localparam int unsigned NCNT_W      = 11;
    localparam int unsigned ACNT_W      = 7;
    localparam int unsigned RCNT_W      = 14;
    localparam int unsigned NCNT_MIN    = 3;
    localparam int unsigned NCNT_MAX    = 2047;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFFSET,
        ST_DIVIDE,
        ST_SPLIT,
        ST_FINISH
    } calc_state_e;

    // Step size in quarter-kHz units; the illegal code maps to a safe divisor.
    function automatic logic [STEP_W-1:0] step_units(input logic [1:0] sel);
        logic [STEP_W-1:0] u;
        unique case (sel)
            2'b00:   u = STEP_W'(100);
            2'b01:   u = STEP_W'(50);
            2'b10:   u = STEP_W'(25);
            default: u = STEP_W'(25);
        endcase
        return u;
    endfunction

    function automatic logic [RCNT_W-1:0] ref_ratio(input logic [1:0] sel);
        logic [RCNT_W-1:0] r;
        if (sel == 2'b11) r = '0;
        else              r = RCNT_W'(REF_Q / int'(step_units(sel)));
        return r;
    endfunction

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int unsigned DVD_W = 23,
    parameter int unsigned DVS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quo_o,
    output logic [DVS_W-1:0] rem_o
);
    localparam int unsigned CNT_W = $clog2(DVD_W + 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W:0]   trial;
    logic [DVS_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem_q, quo_q[DVD_W-1]};
        fits  = trial >= {1'b0, divisor_i};
        diff  = trial - {1'b0, divisor_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            done_o <= 1'b0;
        end else if (start_i) begin
            run_q  <= 1'b1;
            cnt_q  <= CNT_W'(DVD_W);
            quo_q  <= dividend_i;
            rem_q  <= '0;
            done_o <= 1'b0;
        end else if (run_q) begin
            quo_q <= {quo_q[DVD_W-2:0], fits};
            rem_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                run_q  <= 1'b0;
                done_o <= 1'b1;
            end
        end else begin
            done_o <= 1'b0;
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    // R7: the partial remainder of a restoring divider never reaches the divisor
    p_rem_below_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < divisor_i));

    p_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/pll_count_split.sv
module pll_count_split #(
    parameter int unsigned Q_W = 23
) (
    input  logic                               m128_i,
    input  logic [Q_W-1:0]                     total_i,
    output logic [Q_W-1:0]                     main_o,
    output logic [pll_calc_pkg::ACNT_W-1:0]    swal_o,
    output logic                               legal_o
);
    import pll_calc_pkg::*;

    logic [Q_W-1:0] main64, main128;
    logic [ACNT_W-1:0] swal64, swal128;

    // Power-of-two modulus: shift for the main count, mask for the swallow count.
    assign main64  = total_i >> 6;
    assign main128 = total_i >> 7;
    assign swal64  = {1'b0, total_i[5:0]};
    assign swal128 = total_i[6:0];

    always_comb begin
        main_o  = m128_i ? main128 : main64;
        swal_o  = m128_i ? swal128 : swal64;
        legal_o = (main_o >= Q_W'(NCNT_MIN)) && (main_o <= Q_W'(NCNT_MAX))
                  && (Q_W'(swal_o) < main_o);
    end

endmodule

// File: rtl/pll_chan_calc.sv
module pll_chan_calc #(
    parameter int unsigned CH_W = 21
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [CH_W-1:0]                   chan_khz_i,
    input  logic [1:0]                        step_sel_i,
    input  logic                              m128_i,
    output logic                              busy_o,
    output logic                              done_o,
    output logic                              err_o,
    output logic [pll_calc_pkg::NCNT_W-1:0]   n_cnt_o,
    output logic [pll_calc_pkg::ACNT_W-1:0]   a_cnt_o,
    output logic [pll_calc_pkg::RCNT_W-1:0]   r_cnt_o
);
    import pll_calc_pkg::*;

    localparam int unsigned VCO_W   = CH_W + 2;
    localparam int unsigned LAT_MAX = VCO_W + 4;
    localparam int unsigned LAT_W   = $clog2(LAT_MAX + 1);

    calc_state_e state_q, state_d;

    logic [CH_W-1:0]   ch_q;
    logic [1:0]        step_q;
    logic              m128_q;
    logic              bad_q;
    logic [VCO_W-1:0]  chan_q4;
    logic              under;
    logic [VCO_W-1:0]  dividend;
    logic [STEP_W-1:0] divisor;
    logic              div_done;
    logic [VCO_W-1:0]  quo;
    logic [STEP_W-1:0] rem;
    logic [VCO_W-1:0]  main_cnt;
    logic [ACNT_W-1:0] swal_cnt;
    logic              split_ok;
    logic [LAT_W-1:0]  lat_q;

    // Offset removal in quarter-kHz units; a channel at or below the offset is flagged.
    always_comb begin
        chan_q4  = {ch_q, 2'b00};
        under    = chan_q4 <= VCO_W'(OFFSET_Q);
        dividend = under ? '0 : (chan_q4 - VCO_W'(OFFSET_Q));
        divisor  = step_units(step_q);
    end

    pll_restoring_div #(
        .DVD_W (VCO_W),
        .DVS_W (STEP_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (state_q == ST_OFFSET),
        .dividend_i (dividend),
        .divisor_i  (divisor),
        .done_o     (div_done),
        .quo_o      (quo),
        .rem_o      (rem)
    );

    pll_count_split #(
        .Q_W (VCO_W)
    ) u_split (
        .m128_i  (m128_q),
        .total_i (quo),
        .main_o  (main_cnt),
        .swal_o  (swal_cnt),
        .legal_o (split_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)  state_d = ST_OFFSET;
            ST_OFFSET: state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_SPLIT;
            ST_SPLIT:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request capture and registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q    <= '0;
            step_q  <= '0;
            m128_q  <= 1'b0;
            bad_q   <= 1'b0;
            err_o   <= 1'b0;
            n_cnt_o <= '0;
            a_cnt_o <= '0;
            r_cnt_o <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    ch_q   <= chan_khz_i;
                    step_q <= step_sel_i;
                    m128_q <= m128_i;
                end
                ST_OFFSET: bad_q <= under || (step_q == 2'b11);
                ST_SPLIT: begin
                    n_cnt_o <= main_cnt[NCNT_W-1:0];
                    a_cnt_o <= swal_cnt;
                    r_cnt_o <= ref_ratio(step_q);
                    err_o   <= bad_q || (rem != '0) || !split_ok;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = state_q != ST_IDLE;
    assign done_o = state_q == ST_FINISH;

    // Cycle counter for the latency window check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                lat_q <= '0;
        else if (state_q == ST_IDLE) lat_q <= '0;
        else if (lat_q != LAT_W'(LAT_MAX)) lat_q <= lat_q + LAT_W'(1);
    end

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (lat_q < LAT_W'(LAT_MAX)));

    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ch_q) && $stable(step_q) && $stable(m128_q)));

    p_legal_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ((n_cnt_o >= NCNT_W'(NCNT_MIN)) && (NCNT_W'(a_cnt_o) < n_cnt_o)));

    p_ref_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ((32'(r_cnt_o) * 32'(step_units(step_q))) == REF_Q));

endmodule

// File: tb/pll_chan_calc_tb.sv
module pll_chan_calc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [20:0] chan_khz_i = '0;
    logic [1:0]  step_sel_i = '0;
    logic        m128_i = 1'b0;
    logic        busy_o, done_o, err_o;
    logic [10:0] n_cnt_o;
    logic [6:0]  a_cnt_o;
    logic [13:0] r_cnt_o;

    int checks = 0;
    int fails  = 0;
    int done_seen = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pll_chan_calc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .chan_khz_i (chan_khz_i),
        .step_sel_i (step_sel_i),
        .m128_i     (m128_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .n_cnt_o    (n_cnt_o),
        .a_cnt_o    (a_cnt_o),
        .r_cnt_o    (r_cnt_o)
    );

    always @(posedge clk) if (done_o) done_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Launch a job and wait for done; returns the number of negedges waited.
    task automatic launch(input int ch, input int sel, input bit m, output int lat);
        @(negedge clk);
        chan_khz_i = 21'(ch);
        step_sel_i = 2'(sel);
        m128_i     = m;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_job(input string tag, input int ch, input int sel, input bit m,
                           input bit exp_err, input int en, input int ea, input int er);
        int lat;
        launch(ch, sel, m, lat);
        chk(done_o == 1'b1, "R6 done reached", lat, 27);
        chk(lat <= 27, "R6 latency", lat, 27);
        chk(busy_o == 1'b1, "R5 busy with done", int'(busy_o), 1);
        chk(err_o == exp_err, {tag, " err"}, int'(err_o), int'(exp_err));
        if (!exp_err) begin
            chk(int'(n_cnt_o) == en, {tag, " N"}, int'(n_cnt_o), en);
            chk(int'(a_cnt_o) == ea, {tag, " A"}, int'(a_cnt_o), ea);
            chk(int'(r_cnt_o) == er, {tag, " R"}, int'(r_cnt_o), er);
        end
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R5 one-cycle done", int'(done_o), 0);
    endtask

    task automatic t_reset;
        chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(err_o == 1'b0, "R1 err", int'(err_o), 0);
    endtask

    task automatic t_nominal;
        run_job("R2 R4 25k M64", 869725, 0, 1'b0, 1'b0, 530, 1, 850);
        run_job("R4 25k M128", 869725, 0, 1'b1, 1'b0, 265, 1, 850);
        run_job("R3 12.5k M128", 869725, 1, 1'b1, 1'b0, 530, 2, 1700);
        run_job("R3 6.25k M128", 869725, 2, 1'b1, 1'b0, 1060, 4, 3400);
    endtask

    task automatic t_bounds;
        run_job("R8 N max legal", 1659300, 2, 1'b1, 1'b0, 2047, 0, 3400);
        run_job("R8 N min legal", 26550, 0, 1'b0, 1'b0, 3, 2, 850);
        run_job("R8 N over max", 869725, 2, 1'b0, 1'b1, 0, 0, 0);
        run_job("R8 N below min", 21800, 0, 1'b0, 1'b1, 0, 0, 0);
        run_job("R8 A not below N", 29950, 0, 1'b0, 1'b1, 0, 0, 0);
    endtask

    task automatic t_errors;
        run_job("R7 remainder", 869730, 0, 1'b0, 1'b1, 0, 0, 0);
        run_job("R9 below offset", 20000, 0, 1'b0, 1'b1, 0, 0, 0);
        run_job("R9 at offset", 21700, 0, 1'b0, 1'b1, 0, 0, 0);
        run_job("R9 illegal step", 869725, 3, 1'b0, 1'b1, 0, 0, 0);
    endtask

    task automatic t_busy_ignore;
        int lat;
        done_seen = 0;
        @(negedge clk);
        chan_khz_i = 21'(869725);
        step_sel_i = 2'b00;
        m128_i     = 1'b0;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chan_khz_i = 21'(1659300);
        step_sel_i = 2'b10;
        m128_i     = 1'b1;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(int'(n_cnt_o) == 530, "R10 N kept", int'(n_cnt_o), 530);
        chk(int'(a_cnt_o) == 1, "R10 A kept", int'(a_cnt_o), 1);
        chk(int'(r_cnt_o) == 850, "R10 R kept", int'(r_cnt_o), 850);
        repeat (40) @(negedge clk);
        chk(done_seen == 1, "R10 single done", done_seen, 1);
        chk(busy_o == 1'b0, "R10 idle after", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nominal();
        t_bounds();
        t_errors();
        t_busy_ignore();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule